// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a small processor core that completes one instruction per clock. It handles nine instructions: word load and store, five register-to-register operations (add, subtract, AND, OR and signed set-less-than), branch-if-equal and an absolute jump. On each cycle the program counter indexes an internal instruction word array. The fetched word is decoded. Two operands are read from a 32-entry register file, the ALU computes a result, and the result is written to a register or to an internal data word array. The next program counter is then chosen.

Decoding takes place in two steps. A main decoder looks only at the 6-bit opcode and produces the datapath controls and a 2-bit ALU class code. The class code means add, subtract, or "use the function field". A small local decoder turns that code, together with the function field of register-format words, into the actual ALU operation.

Both memories are preloaded through a simple write port while reset is held. Every register or memory write the core performs is reported on commit outputs in the same cycle as the instruction that causes it. This lets an environment follow execution without looking inside the block.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0. During reset, `rf_we_o` and `dm_we_o` stay low and the core writes nothing.
- R2: `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` describe the register write of the instruction shown on `instr_o` in the same cycle. `dm_we_o`, `dm_addr_o` (byte address) and `dm_wdata_o` describe its store in the same way. No instruction does both.
- R3: Opcode 000000 is register format, with rs in [25:21], rt in [20:16], rd in [15:11] and function in [5:0]. Function 100000 writes rs+rt to rd, 100010 writes rs−rt, 100100 writes rs AND rt, and 100101 writes rs OR rt.
- R4: Function 100010 is subtract, and function 101010 writes 1 to rd when rs < rt as two's-complement values. Otherwise it writes 0.
- R5: Opcode 100011 loads the data word at byte address rs + sign-extended [15:0] into rt.
- R6: Opcode 101011 stores rt at byte address rs + sign-extended [15:0] and writes no register.
- R7: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 + (sign-extended [15:0] << 2). Otherwise it is PC+4. No register or memory is written.
- R8: Opcode 000010 sets the PC to {(PC+4)[31:28], [25:0], 00} and writes nothing.
- R9: Register 0 always reads as 0. A write aimed at it is dropped, and `rf_we_o` stays low for it.
- R10: Any other opcode, or a register-format word with any other function code, writes nothing and advances the PC by 4.
- R11: The instruction fetched is word PC[MAW+1:2] of the instruction array. The data word accessed is address[MAW+1:2]. Both wrap modulo `MEM_WORDS`.
- R12: `load_imem` or `load_dmem` writes `load_data` to word `load_idx` of that array at the rising edge. A load write takes priority over a core store to the same array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_imem | input | 1 | Preload strobe for the instruction array |
| load_dmem | input | 1 | Preload strobe for the data array |
| load_idx | input | MAW | Word index for preload |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written to the register |
| dm_we_o | output | 1 | Data store this cycle |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Stored value |

## Verification
The clocked properties assume that a program comes only from the instruction array. They also assume the preload strobes are used only while reset is high, so that a load never races a fetch the properties reason about. The stimulus keeps to this. It fills both arrays completely during reset and then leaves the load port idle. The program mixes directed words with random words drawn from the supported encodings. It adds two deliberately unsupported words. Branch offsets are non-negative and jump targets lie inside the array, so execution keeps moving through the whole program.

// File: rtl/rcore_pkg.sv
`timescale 1ns/1ps
package rcore_pkg;
    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RAW   = $clog2(NREGS);

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // ALU class code from the main decoder
    localparam logic [1:0] CLS_ADD   = 2'b00;
    localparam logic [1:0] CLS_SUB   = 2'b01;
    localparam logic [1:0] CLS_FUNCT = 2'b10;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_sel_e;

    typedef struct packed {
        logic       dst_rd;    // write rd instead of rt
        logic       imm_b;     // ALU operand B is the immediate
        logic       wb_mem;    // write-back comes from data memory
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       branch;
        logic       jump;
        logic [1:0] cls;
    } ctrl_t;
endpackage

// File: rtl/rcore_maindec.sv
`timescale 1ns/1ps
module rcore_maindec
    import rcore_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.cls = CLS_ADD;
        case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.imm_b  = 1'b1;
                ctrl.wb_mem = 1'b1;
                ctrl.reg_wr = 1'b1;
                ctrl.mem_rd = 1'b1;
            end
            OPC_STORE: begin
                ctrl.imm_b  = 1'b1;
                ctrl.mem_wr = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/rcore_aluctl.sv
`timescale 1ns/1ps
module rcore_aluctl
    import rcore_pkg::*;
(
    input  logic [1:0] cls,
    input  logic [5:0] funct,
    output alu_sel_e   sel,
    output logic       ok
);
    always_comb begin
        sel = ALU_ADD;
        ok  = 1'b1;
        case (cls)
            CLS_ADD: sel = ALU_ADD;
            CLS_SUB: sel = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  sel = ALU_ADD;
                    FN_SUB:  sel = ALU_SUB;
                    FN_AND:  sel = ALU_AND;
                    FN_OR:   sel = ALU_OR;
                    FN_SLT:  sel = ALU_SLT;
                    default: ok  = 1'b0;
                endcase
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/rcore_regfile.sv
`timescale 1ns/1ps
module rcore_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic          we,
    output logic [W-1:0]  rda,
    output logic [W-1:0]  rdb
);
    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rda = (ra == '0) ? '0 : regs_q[ra];
    assign rdb = (rb == '0) ? '0 : regs_q[rb];
endmodule

// File: rtl/rcore_wordmem.sv
`timescale 1ns/1ps
module rcore_wordmem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic          st_we,
    input  logic [AW-1:0] st_idx,
    input  logic [W-1:0]  st_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [WORDS];
    logic [W-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (st_we) mem_d[st_idx] = st_data;
        if (ld_we) mem_d[ld_idx] = ld_data;   // preload wins
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/rcore_top.sv
`timescale 1ns/1ps
module rcore_top
    import rcore_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int MAW = $clog2(MEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_imem,
    input  logic             load_dmem,
    input  logic [MAW-1:0]   load_idx,
    input  logic [XLEN-1:0]  load_data,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  instr_o,
    output logic             rf_we_o,
    output logic [RAW-1:0]   rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             dm_we_o,
    output logic [XLEN-1:0]  dm_addr_o,
    output logic [XLEN-1:0]  dm_wdata_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] opa, opb, rdb, alu_res, simm, dm_rdata;
    logic [XLEN-1:0] pc_seq, pc_br, pc_jmp;
    logic [RAW-1:0]  wr_addr;
    logic            alu_ok, is_zero, wr_en, st_en;
    ctrl_t           ctrl;
    alu_sel_e        alu_sel;

    // fetch
    rcore_wordmem #(.W(XLEN), .WORDS(MEM_WORDS)) u_imem (
        .clk     (clk),
        .ld_we   (load_imem),
        .ld_idx  (load_idx),
        .ld_data (load_data),
        .st_we   (1'b0),
        .st_idx  ('0),
        .st_data ('0),
        .rd_idx  (st_q.pc[MAW+1:2]),
        .rd_data (instr)
    );

    // decode
    rcore_maindec u_main (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    rcore_aluctl u_aluctl (
        .cls   (ctrl.cls),
        .funct (instr[5:0]),
        .sel   (alu_sel),
        .ok    (alu_ok)
    );

    assign simm    = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign wr_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign wr_en   = ctrl.reg_wr && alu_ok && (wr_addr != '0) && !rst;
    assign st_en   = ctrl.mem_wr && !rst;

    rcore_regfile #(.W(XLEN), .N(NREGS)) u_regs (
        .clk (clk),
        .rst (rst),
        .ra  (instr[25:21]),
        .rb  (instr[20:16]),
        .wa  (wr_addr),
        .wd  (rf_wdata_o),
        .we  (wr_en),
        .rda (opa),
        .rdb (rdb)
    );

    // execute
    assign opb = ctrl.imm_b ? simm : rdb;

    always_comb begin
        case (alu_sel)
            ALU_ADD: alu_res = opa + opb;
            ALU_SUB: alu_res = opa - opb;
            ALU_AND: alu_res = opa & opb;
            ALU_OR:  alu_res = opa | opb;
            ALU_SLT: alu_res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: alu_res = '0;
        endcase
    end

    assign is_zero = (alu_res == '0);

    // memory
    rcore_wordmem #(.W(XLEN), .WORDS(MEM_WORDS)) u_dmem (
        .clk     (clk),
        .ld_we   (load_dmem),
        .ld_idx  (load_idx),
        .ld_data (load_data),
        .st_we   (st_en),
        .st_idx  (alu_res[MAW+1:2]),
        .st_data (rdb),
        .rd_idx  (alu_res[MAW+1:2]),
        .rd_data (dm_rdata)
    );

    // next PC
    assign pc_seq = st_q.pc + 32'd4;
    assign pc_br  = pc_seq + {simm[XLEN-3:0], 2'b00};
    assign pc_jmp = {pc_seq[31:28], instr[25:0], 2'b00};

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_seq;
        if (ctrl.branch && is_zero) st_d.pc = pc_br;
        if (ctrl.jump)              st_d.pc = pc_jmp;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // commit reporting
    assign pc_o       = st_q.pc;
    assign instr_o    = instr;
    assign rf_we_o    = wr_en;
    assign rf_waddr_o = wr_addr;
    assign rf_wdata_o = (ctrl.wb_mem && ctrl.mem_rd) ? dm_rdata : alu_res;
    assign dm_we_o    = st_en;
    assign dm_addr_o  = alu_res;
    assign dm_wdata_o = rdb;
endmodule

// File: rtl/rcore_chk.sv
`timescale 1ns/1ps
module rcore_chk
    import rcore_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] instr_o,
    input logic            rf_we_o,
    input logic [RAW-1:0]  rf_waddr_o,
    input logic            dm_we_o
);
    logic [XLEN-1:0] seq4;
    assign seq4 = pc_o + 32'd4;

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc_o == '0));

    // R1
    pc_align_chk: assert property (@(posedge clk) disable iff (rst) pc_o[1:0] == 2'b00);

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (rf_waddr_o != '0));

    // R2
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(rf_we_o && dm_we_o));

    // R6
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> (instr_o[31:26] == OPC_STORE));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_o[31:26] == OPC_JUMP) |=>
            (pc_o == {$past(seq4[31:28]), $past(instr_o[25:0]), 2'b00}));

    // R10
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_o[31:26] != OPC_JUMP && instr_o[31:26] != OPC_BEQ) |=>
            (pc_o == $past(seq4)));
endmodule

bind rcore_top rcore_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .instr_o    (instr_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .dm_we_o    (dm_we_o)
);

// File: tb/rcore_top_test.sv
`timescale 1ns/1ps
module rcore_top_test;
    localparam int WORDS  = 64;
    localparam int AW     = 6;
    localparam int CYCLES = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_imem = 1'b0;
    logic          load_dmem = 1'b0;
    logic [AW-1:0] load_idx = '0;
    logic [31:0]   load_data = '0;
    logic [31:0]   pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]    rf_waddr_o;
    logic          rf_we_o, dm_we_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_reg  [32];
    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_pc;

    rcore_top #(.MEM_WORDS(WORDS)) uut (
        .clk(clk), .rst(rst), .load_imem(load_imem), .load_dmem(load_dmem),
        .load_idx(load_idx), .load_data(load_data), .pc_o(pc_o), .instr_o(instr_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rt_word(input int rs, input int rt, input int rd,
                                            input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
    endfunction

    function automatic logic [31:0] it_word(input logic [5:0] op, input int rs,
                                            input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [5:0] pick_fn(input int k);
        case (k)
            0: return 6'b100000;
            1: return 6'b100010;
            2: return 6'b100100;
            3: return 6'b100101;
            default: return 6'b101010;
        endcase
    endfunction

    function automatic logic [31:0] rand_word();
        int r = $urandom_range(0, 99);
        int a = $urandom_range(0, 7);
        int b = $urandom_range(0, 7);
        int c = $urandom_range(0, 8);
        if (r < 28) return it_word(6'b100011, a, b, $urandom_range(0, 15) * 4);
        if (r < 42) return it_word(6'b101011, a, b, $urandom_range(0, 15) * 4);
        if (r < 84) return rt_word(a, b, c, pick_fn($urandom_range(0, 4)));
        if (r < 94) return it_word(6'b000100, a, b, $urandom_range(0, 5));
        return {6'b000010, 26'($urandom_range(0, WORDS - 1))};
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        case (w[31:26])
            6'b000000: begin
                if (w[5:0] == 6'b101010) return "R4";
                if (w[5:0] inside {6'b100000, 6'b100010, 6'b100100, 6'b100101})
                    return (w[15:11] == 5'd0) ? "R9" : "R3";
                return "R10";
            end
            6'b100011: return (w[20:16] == 5'd0) ? "R9" : "R5";
            6'b101011: return "R6";
            6'b000100: return "R7";
            6'b000010: return "R8";
            default:   return "R10";
        endcase
    endfunction

    // one instruction: compare the commit ports with the ISA model, then advance it
    task automatic step_check();
        logic [31:0] w, a, b, simm, res, nxt, wdat;
        logic        we, se;
        logic [4:0]  dst;
        string       t;
        w    = m_imem[m_pc[AW+1:2]];
        t    = tag_of(w);
        a    = m_reg[w[25:21]];
        b    = m_reg[w[20:16]];
        simm = {{16{w[15]}}, w[15:0]};
        nxt  = m_pc + 32'd4;
        we   = 1'b0; se = 1'b0; dst = w[20:16]; res = 32'd0; wdat = 32'd0;
        case (w[31:26])
            6'b000000: begin
                dst = w[15:11];
                we  = 1'b1;
                case (w[5:0])
                    6'b100000: res = a + b;
                    6'b100010: res = a - b;
                    6'b100100: res = a & b;
                    6'b100101: res = a | b;
                    6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default:   we  = 1'b0;
                endcase
                wdat = res;
            end
            6'b100011: begin
                res = a + simm; we = 1'b1; wdat = m_dmem[res[AW+1:2]];
            end
            6'b101011: begin
                res = a + simm; se = 1'b1;
            end
            6'b000100: if (a == b) nxt = m_pc + 32'd4 + {simm[29:0], 2'b00};
            6'b000010: nxt = {nxt[31:28], w[25:0], 2'b00};
            default: ;
        endcase
        if (dst == 5'd0) we = 1'b0;
        chk("R11", "pc_o", pc_o, m_pc);
        chk("R11/R12", "instr_o", instr_o, w);
        chk($sformatf("R2/%s", t), "rf_we_o", {31'b0, rf_we_o}, {31'b0, we});
        if (we) begin
            chk($sformatf("R2/%s", t), "rf_waddr_o", {27'b0, rf_waddr_o}, {27'b0, dst});
            chk($sformatf("R2/%s", t), "rf_wdata_o", rf_wdata_o, wdat);
            m_reg[dst] = wdat;
        end
        chk($sformatf("R2/%s", t), "dm_we_o", {31'b0, dm_we_o}, {31'b0, se});
        if (se) begin
            chk("R6", "dm_addr_o", dm_addr_o, res);
            chk("R6", "dm_wdata_o", dm_wdata_o, b);
            m_dmem[res[AW+1:2]] = b;
        end
        m_pc = nxt;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        m_pc = 32'd0;
    endtask

    initial begin
        void'($urandom(32'd20417));
        // directed prologue
        m_imem[0]  = it_word(6'b100011, 0, 1, 0);        // r1 = negative word
        m_imem[1]  = it_word(6'b100011, 0, 2, 4);        // r2 = 7
        m_imem[2]  = rt_word(1, 2, 3, 6'b101010);        // R4: r3 = 1
        m_imem[3]  = rt_word(2, 1, 4, 6'b101010);        // R4: r4 = 0
        m_imem[4]  = rt_word(1, 2, 0, 6'b100000);        // R9: write to r0 dropped
        m_imem[5]  = rt_word(2, 1, 5, 6'b100010);        // R3 sub
        m_imem[6]  = rt_word(1, 2, 6, 6'b100100);        // R3 and
        m_imem[7]  = rt_word(1, 2, 7, 6'b100101);        // R3 or
        m_imem[8]  = it_word(6'b101011, 0, 5, 8);        // R6 store
        m_imem[9]  = it_word(6'b100011, 0, 8, 8);        // R5 reload
        m_imem[10] = it_word(6'b000100, 3, 4, 5);        // R7 not taken
        m_imem[11] = it_word(6'b000100, 0, 0, 1);        // R7 taken, skips 12
        m_imem[12] = rt_word(1, 1, 9, 6'b100000);
        m_imem[13] = 32'hFC00_1234;                      // R10 unknown opcode
        m_imem[14] = rt_word(1, 2, 10, 6'b000000);       // R10 unknown function
        m_imem[15] = {6'b000010, 26'd17};                // R8 jump to word 17
        m_imem[16] = rt_word(1, 1, 11, 6'b100000);
        for (int i = 17; i < WORDS; i++) m_imem[i] = rand_word();
        m_dmem[0] = 32'h8000_0005;
        m_dmem[1] = 32'h0000_0007;
        for (int i = 2; i < WORDS; i++) m_dmem[i] = $urandom();
        model_reset();

        repeat (2) @(negedge clk);
        for (int i = 0; i < WORDS; i++) begin
            load_imem = 1'b1; load_dmem = 1'b1;
            load_idx  = AW'(i); load_data = m_imem[i];
            @(negedge clk);
            load_imem = 1'b0;
            load_data = m_dmem[i];
            @(negedge clk);
        end
        load_dmem = 1'b0;
        @(negedge clk);
        chk("R1", "pc_o in reset", pc_o, 32'd0);
        chk("R1", "rf_we_o in reset", {31'b0, rf_we_o}, 32'd0);
        chk("R1", "dm_we_o in reset", {31'b0, dm_we_o}, 32'd0);
        rst = 1'b0;
        #1;
        for (int c = 0; c < CYCLES; c++) begin
            step_check();
            @(negedge clk);
            #1;
            if (c == CYCLES / 2) begin
                rst = 1'b1;
                @(negedge clk);
                #1;
                chk("R1", "pc_o after mid reset", pc_o, 32'd0);
                chk("R1", "rf_we_o held in reset", {31'b0, rf_we_o}, 32'd0);
                chk("R1", "dm_we_o held in reset", {31'b0, dm_we_o}, 32'd0);
                rst = 1'b0;
                model_reset();
                #1;
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule